// File: doc/BRIEF.md
# Two-Wire Alternating-Strobe Frame Receiver

This block listens on a pair of bidirectional bus lines once the local side has finished sending, and it recovers the reply frame. After an `arm` pulse it waits a bounded number of cycles for any line activity. It then discards the start pattern until the first phase-one state (line A high, line B low). From that point it takes one data bit on every falling edge of the line whose turn it is to strobe. Line A strobes first. The strobe role then swaps between the lines on every bit, and the bit value is the level of the other line.

Bits are packed MSB first into bytes, which leave on a byte stream with a valid strobe. The stream is held back by one byte, so the final byte can carry a last flag. The frame ends when the line that is not due to strobe falls. At that point the block checks the frame. The byte count less one, for the checksum byte, must be a multiple of four, and the XOR of all bytes must be zero. It then raises `done` for one cycle, with a result code and the byte count. Both lines pass through a two-flop synchronizer, and edges are taken from the synchronized values.

Top module: `alt_phase_rx`

## Requirements
- R1: If neither line changes within WAIT_CYCLES cycles after `arm`, `done` pulses with `status` = 2'b01 (timeout), `byte_count` = 0 and no byte on the stream.
- R2: Falling edges seen before the first synchronized state with line A = 1 and line B = 0 are ignored and produce no bits.
- R3: After the start state, the bit on an expected falling edge of line A is the level of line B, and the bit on an expected falling edge of line B is the level of line A. The first expected strobe is line A, and the expected line alternates on every bit.
- R4: Bits are packed MSB first. Every eighth bit completes a byte, and that byte appears on `rx_byte` with `rx_valid` high for one cycle, in arrival order.
- R5: A falling edge on the line that is not expected to strobe ends the frame. The held byte leaves with `rx_valid` and `rx_last` both high, in the same cycle as the `done` pulse.
- R6: When a byte completes while MAX_BYTES bytes are already accepted, reception stops. `done` pulses with `status` = 2'b11 (overflow) and `byte_count` = MAX_BYTES, and no byte is flagged last.
- R7: At frame end, `status` = 2'b10 (frame error) if the byte count n has (n-1) mod 4 not equal to 0, if n = 0, or if a partial byte is pending.
- R8: At frame end, `status` = 2'b10 if the XOR of all received bytes, checksum included, is nonzero.
- R9: A frame that passes both checks ends with `status` = 2'b00 and `byte_count` equal to the number of bytes received, checksum included.
- R10: After reset, `rx_valid`, `rx_last` and `done` are low, and `status` and `byte_count` are zero. `done` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm | input | 1 | One-cycle pulse that starts a new reception |
| line_a | input | 1 | Bus line A, asynchronous |
| line_b | input | 1 | Bus line B, asynchronous |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_byte` is valid this cycle |
| rx_last | output | 1 | This byte is the final one of the frame |
| done | output | 1 | One-cycle pulse when reception ends |
| status | output | 2 | Result: 00 ok, 01 timeout, 10 frame/checksum error, 11 overflow |
| byte_count | output | CNT_W | Bytes accepted, valid with `done` |

## Verification
The assertions assume three things about the inputs. The two lines never fall in the same synchronized cycle. Every line level is held for at least two clock cycles, so the synchronizer and the edge detector see each change. `arm` is pulsed only when the lines rest high and no frame is in flight. The bench drives each line step for three cycles. Every bit uses the rise-set-fall order in which only the expected strobe line falls. The bench arms only after the previous `done` has been seen, so the stimulus stays inside these assumptions.

// File: rtl/alt_phase_rx.sv
module alt_phase_rx #(
  parameter int WAIT_CYCLES = 1000,
  parameter int MAX_BYTES   = 640,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int TMR_W = $clog2(WAIT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             line_a,
  input  logic             line_b,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             rx_last,
  output logic             done,
  output logic [1:0]       status,
  output logic [CNT_W-1:0] byte_count
);

  localparam logic [1:0] ST_OK   = 2'b00;
  localparam logic [1:0] ST_TMO  = 2'b01;
  localparam logic [1:0] ST_FRM  = 2'b10;
  localparam logic [1:0] ST_OVF  = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SKIP, S_DATA} st_t;

  st_t              state;
  logic [1:0]       sa, sb;
  logic             pa, pb;
  logic [TMR_W-1:0] tmr;
  logic             turn_b;
  logic [2:0]       bitn;
  logic [7:0]       shreg, pend, xacc;
  logic             have_pend;
  logic [CNT_W-1:0] cnt;

  logic a_s, b_s;
  assign a_s = sa[1];
  assign b_s = sb[1];

  logic fall_a, fall_b, changed, strobe, stray, bit_in;
  logic [7:0] new_byte;
  logic [1:0] end_code;
  assign fall_a   = pa & ~a_s;
  assign fall_b   = pb & ~b_s;
  assign changed  = (pa != a_s) || (pb != b_s);
  assign strobe   = turn_b ? fall_b : fall_a;
  assign stray    = turn_b ? fall_a : fall_b;
  assign bit_in   = turn_b ? a_s : b_s;
  assign new_byte = {shreg[6:0], bit_in};
  assign end_code = (bitn != 3'd0 || cnt[1:0] != 2'b01 || xacc != 8'd0) ? ST_FRM : ST_OK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sa <= 2'b11; sb <= 2'b11; pa <= 1'b1; pb <= 1'b1;
      tmr <= '0; turn_b <= 1'b0; bitn <= '0;
      shreg <= '0; pend <= '0; xacc <= '0; have_pend <= 1'b0; cnt <= '0;
      rx_byte <= '0; rx_valid <= 1'b0; rx_last <= 1'b0;
      done <= 1'b0; status <= ST_OK; byte_count <= '0;
    end else begin
      sa <= {sa[0], line_a};
      sb <= {sb[0], line_b};
      pa <= a_s;
      pb <= b_s;
      rx_valid <= 1'b0;
      rx_last  <= 1'b0;
      done     <= 1'b0;
      if (arm) begin
        state <= S_WAIT;
        tmr <= '0; turn_b <= 1'b0; bitn <= '0;
        xacc <= '0; have_pend <= 1'b0; cnt <= '0;
        status <= ST_OK; byte_count <= '0;
      end else begin
        case (state)
          S_WAIT: begin
            if (changed) state <= S_SKIP;
            else if (tmr == TMR_W'(WAIT_CYCLES - 1)) begin
              state <= S_IDLE; done <= 1'b1; status <= ST_TMO; byte_count <= '0;
            end else tmr <= tmr + 1'b1;
          end
          S_SKIP: if (a_s && !b_s) state <= S_DATA;
          S_DATA: begin
            if (stray) begin
              state <= S_IDLE;
              done <= 1'b1;
              status <= end_code;
              byte_count <= cnt;
              if (have_pend) begin
                rx_byte <= pend; rx_valid <= 1'b1; rx_last <= 1'b1;
              end
            end else if (strobe) begin
              turn_b <= ~turn_b;
              bitn <= bitn + 1'b1;
              shreg <= new_byte;
              if (bitn == 3'd7) begin
                if (have_pend) begin
                  rx_byte <= pend; rx_valid <= 1'b1;
                end
                if (cnt == CNT_W'(MAX_BYTES)) begin
                  state <= S_IDLE; done <= 1'b1; status <= ST_OVF; byte_count <= cnt;
                end else begin
                  pend <= new_byte; have_pend <= 1'b1;
                  cnt <= cnt + 1'b1;
                  xacc <= xacc ^ new_byte;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  timeout_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == ST_TMO |-> byte_count == '0 && !rx_valid);

  // R5
  last_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last |-> rx_valid && done && status != ST_OVF);

  // R5
  end_flags_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == ST_OK || status == ST_FRM) && byte_count != '0 |-> rx_valid && rx_last);

  // R6
  ovf_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == ST_OVF |-> byte_count == CNT_W'(MAX_BYTES) && !rx_last);

  // R9
  ok_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == ST_OK |-> byte_count[1:0] == 2'b01);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/alt_phase_rx_test.sv
module alt_phase_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;
  localparam int WAITC = 64;
  localparam int MAXB = 9;
  localparam int CW = $clog2(MAXB + 1);
  localparam int NV = 7;
  localparam int VPAY [NV] = '{4, 8, 4, 5, 0, 0, 12};
  localparam int VBAD [NV] = '{0, 0, 1, 0, 0, 1, 0};
  localparam int VSEED[NV] = '{3, 17, 29, 41, 5, 7, 11};

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, la = 1'b1, lb = 1'b1;
  logic [7:0] rx_byte;
  logic rx_valid, rx_last, done;
  logic [1:0] status;
  logic [CW-1:0] byte_count;

  alt_phase_rx #(.WAIT_CYCLES(WAITC), .MAX_BYTES(MAXB)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .line_a(la), .line_b(lb),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_last(rx_last),
    .done(done), .status(status), .byte_count(byte_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  int ng = 0, ndone = 0, base_g = 0, base_d = 0, bpos = 0;
  logic [7:0] got [0:255];
  logic gl [0:255];
  logic [1:0] got_stat;
  int got_cnt;
  logic [7:0] frame [0:31];

  always @(negedge clk) begin
    if (rx_valid) begin got[ng] = rx_byte; gl[ng] = rx_last; ng = ng + 1; end
    if (done) begin got_stat = status; got_cnt = int'(byte_count); ndone = ndone + 1; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nerr = nerr + 1; nchk = nchk + 1;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic b);
    la = a; lb = b;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    if (bpos % 2 == 0) begin step(1'b1, lb); step(1'b1, v); step(1'b0, v); end
    else begin step(la, 1'b1); step(v, 1'b1); step(v, 1'b0); end
    bpos++;
  endtask

  task automatic start_rx();
    base_g = ng; base_d = ndone;
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    step(0, 1); step(0, 0); step(0, 1); step(1, 1); step(0, 1); step(0, 0); step(1, 0);
    bpos = 0;
  endtask

  task automatic finish_rx();
    if (bpos % 2 == 0) begin step(1, 0); step(1, 1); step(1, 0); end
    else begin step(0, 1); step(1, 1); step(0, 1); end
    step(1, 1);
    for (int k = 0; k < 200 && ndone == base_d; k++) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input int extra);
    start_rx();
    for (int i = 0; i < n; i++)
      for (int j = 7; j >= 0; j--) send_bit(frame[i][j]);
    for (int e = 0; e < extra; e++) send_bit(e[0]);
    finish_rx();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rx_valid", int'(rx_valid), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 status", int'(status), 0);
    chk("R10 byte_count", int'(byte_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int n, expn, exps;
      logic [7:0] x;
      x = 8'h00;
      for (int i = 0; i < VPAY[v]; i++) begin
        frame[i] = 8'(VSEED[v] * (i + 3) + i * i) ^ 8'hA5;
        x = x ^ frame[i];
      end
      frame[VPAY[v]] = (VBAD[v] != 0) ? (x ^ 8'h11) : x;
      n = VPAY[v] + 1;
      run_frame(n, 0);
      exps = (n > MAXB) ? 3 : (((n - 1) % 4 != 0 || VBAD[v] != 0) ? 2 : 0);
      expn = (n > MAXB) ? MAXB : n;
      chk("R5 done seen", ndone - base_d, 1);
      chk("R6/R7/R8/R9 status", int'(got_stat), exps);
      chk("R2/R4 byte total", ng - base_g, expn);
      for (int i = 0; i < expn; i++) begin
        chk("R3/R4 byte value", int'(got[base_g + i]), int'(frame[i]));
        chk("R5/R6 last flag", int'(gl[base_g + i]), (exps != 3 && i == expn - 1) ? 1 : 0);
      end
      if (exps == 0 || exps == 3) chk("R6/R9 byte_count", got_cnt, expn);
    end

    // R7 partial byte pending at end
    frame[0] = 8'h12; frame[1] = 8'h34; frame[2] = 8'h56; frame[3] = 8'h78;
    frame[4] = 8'h12 ^ 8'h34 ^ 8'h56 ^ 8'h78;
    run_frame(5, 3);
    chk("R7 partial status", int'(got_stat), 2);
    chk("R7 partial bytes", ng - base_g, 5);
    chk("R5 partial last", int'(gl[base_g + 4]), 1);

    // R1 timeout with idle lines
    base_g = ng; base_d = ndone;
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    repeat (WAITC + 10) @(negedge clk);
    chk("R1 timeout done", ndone - base_d, 1);
    chk("R1 timeout status", int'(got_stat), 1);
    chk("R1 timeout count", got_cnt, 0);
    chk("R1 timeout bytes", ng - base_g, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule